// File: doc/BRIEF.md
# Guarded Pointer Segment Checker

This block works on tagged 64-bit guarded pointers. Each pointer word carries a permission field, a segment-length field and an address field, and a separate validity tag travels with the word. The segment-length value says how many low address bits may change inside the segment. Every segment is therefore an aligned power-of-two region around the address.

A request carries a pointer, its tag, a signed offset and an operation code. The operation adds the offset to the pointer, checks a load, checks a store, or inspects the pointer. The response appears one cycle later. It carries the result pointer, the result tag, a fault flag, and the base and limit of the segment of the pointer that came in. Pointer arithmetic never faults. When the result address leaves its segment, the block clears the tag instead, and no later arithmetic can set it again. A load or store check faults unless the tag is set and the needed permission bit is present.

Top module: `gp_seg_unit`

## Requirements
- R1: Pointer word layout: permission field in bits [63:60], segment length in bits [59:54], address in bits [53:0]. Operation codes: 0 = add offset, 1 = load check, 2 = store check, 3 = inspect.
- R2: Every request with req_valid high gives rsp_valid high exactly one cycle later, and rsp_valid is low one cycle after a cycle without a request.
- R3: rsp_base is the input address with its low L bits forced to 0, and rsp_limit is the same address with those bits forced to 1. L is the segment length capped at 54. For example, address 0x1234 with length 8 gives base 0x1200 and limit 0x12ff. A length of 54 or more gives base 0 and an all-ones limit.
- R4: An add returns an address of (address + offset) modulo 2^54, taken from the low 54 offset bits. Permission and length are copied unchanged.
- R5: An add returns tag = input tag AND (the address bits above L are the same before and after the add). With a length of 54 or more, a set tag is never cleared.
- R6: A clear input tag always gives a clear result tag, for every operation. A pointer that has left its segment stays untagged when later arithmetic brings it back.
- R7: An add never asserts rsp_fault.
- R8: A load check faults exactly when the tag is clear or permission bit 0 (read) is clear. A store check faults exactly when the tag is clear or permission bit 1 (write) is clear. Permission bits 2 and 3 have no effect. Both checks return the word and the tag unchanged.
- R9: Inspect returns the word and the tag unchanged and never faults.
- R10: While reset is held, all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code |
| req_tag | input | 1 | Validity tag of the input pointer |
| req_word | input | 64 | Input pointer word |
| req_offset | input | 64 | Signed offset for the add operation |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_tag | output | 1 | Result tag |
| rsp_word | output | 64 | Result pointer word |
| rsp_fault | output | 1 | Access fault for a load or store check |
| rsp_base | output | 54 | Lowest address of the input segment |
| rsp_limit | output | 54 | Highest address of the input segment |

## Verification
The assertions check these behaviours on every cycle:
- the one-cycle response strobe;
- that a clear tag never turns into a set tag;
- that an add never faults;
- that loads and stores fault on an untagged or unpermitted pointer;
- that a whole-field segment keeps its tag;
- that the base never lies above the limit.

The exact values need the bench's sweeps:
- the result address, including wraparound at 2^54;
- the tag-clearing boundary at each segment length;
- the precise base and limit;
- the return trip of a pointer that left its segment and came back.

// File: rtl/gp_seg_unit.sv
module gp_seg_unit #(
  parameter int ADDR_W = 54,
  parameter int LEN_W  = 6,
  parameter int PERM_W = 4,
  parameter int RD_BIT = 0,
  parameter int WR_BIT = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic [1:0]                       req_op,
  input  logic                             req_tag,
  input  logic [PERM_W+LEN_W+ADDR_W-1:0]   req_word,
  input  logic [PERM_W+LEN_W+ADDR_W-1:0]   req_offset,
  output logic                             rsp_valid,
  output logic                             rsp_tag,
  output logic [PERM_W+LEN_W+ADDR_W-1:0]   rsp_word,
  output logic                             rsp_fault,
  output logic [ADDR_W-1:0]                rsp_base,
  output logic [ADDR_W-1:0]                rsp_limit
);
  localparam int WORD_W = PERM_W + LEN_W + ADDR_W;
  localparam logic [1:0] OP_ADD = 2'd0, OP_LD = 2'd1, OP_ST = 2'd2;

  logic [ADDR_W-1:0] in_addr, sum, seg_mask;
  logic [LEN_W-1:0]  in_len;
  logic [PERM_W-1:0] in_perm;
  logic              in_seg;
  logic              n_tag, n_fault;
  logic [WORD_W-1:0] n_word;

  assign in_addr = req_word[ADDR_W-1:0];
  assign in_len  = req_word[ADDR_W+LEN_W-1:ADDR_W];
  assign in_perm = req_word[WORD_W-1:ADDR_W+LEN_W];
  assign sum     = in_addr + req_offset[ADDR_W-1:0];

  always_comb
    for (int i = 0; i < ADDR_W; i++) seg_mask[i] = (i < int'(in_len));

  assign in_seg = (((sum ^ in_addr) & ~seg_mask) == '0);

  always_comb begin
    n_word  = req_word;
    n_tag   = req_tag;
    n_fault = 1'b0;
    case (req_op)
      OP_ADD: begin
        n_word = {in_perm, in_len, sum};
        n_tag  = req_tag & in_seg;
      end
      OP_LD: n_fault = ~req_tag | ~in_perm[RD_BIT];
      OP_ST: n_fault = ~req_tag | ~in_perm[WR_BIT];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= 1'b0;
      rsp_word  <= '0;
      rsp_fault <= 1'b0;
      rsp_base  <= '0;
      rsp_limit <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_tag   <= n_tag;
        rsp_word  <= n_word;
        rsp_fault <= n_fault;
        rsp_base  <= in_addr & ~seg_mask;
        rsp_limit <= in_addr | seg_mask;
      end
    end
  end
endmodule

// File: rtl/gp_seg_unit_chk.sv
module gp_seg_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic        req_tag,
  input logic [63:0] req_word,
  input logic        rsp_valid,
  input logic        rsp_tag,
  input logic        rsp_fault,
  input logic [53:0] rsp_base,
  input logic [53:0] rsp_limit
);
  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R6
  tag_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_tag) |=> !rsp_tag);
  // R7
  add_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0) |=> !rsp_fault);
  // R8
  load_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1 && (!req_tag || !req_word[60])) |=> rsp_fault);
  // R8
  store_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && (!req_tag || !req_word[61])) |=> rsp_fault);
  // R5
  whole_field_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && req_tag && req_word[59:54] >= 6'd54) |=> rsp_tag);
  // R3
  base_le_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_base <= rsp_limit);
endmodule

bind gp_seg_unit gp_seg_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_tag(req_tag), .req_word(req_word), .rsp_valid(rsp_valid),
  .rsp_tag(rsp_tag), .rsp_fault(rsp_fault), .rsp_base(rsp_base),
  .rsp_limit(rsp_limit));

// File: tb/sim_gp_seg_unit.sv
module sim_gp_seg_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_tag = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [63:0] req_word = '0, req_offset = '0;
  logic rsp_valid, rsp_tag, rsp_fault;
  logic [63:0] rsp_word;
  logic [53:0] rsp_base, rsp_limit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gp_seg_unit u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_tag(req_tag), .req_word(req_word), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_word(rsp_word),
    .rsp_fault(rsp_fault), .rsp_base(rsp_base), .rsp_limit(rsp_limit));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [53:0] mk(input int len);
    if (len >= 54) return '1;
    return (54'(1) << len) - 54'(1);
  endfunction

  task automatic issue(input logic [1:0] op, input logic tag, input logic [63:0] w, input logic [63:0] off);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_tag = tag; req_word = w; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_req(input logic [1:0] op, input logic tag, input logic [63:0] w, input logic [63:0] off);
    logic [53:0] a, m, s;
    logic [63:0] ew;
    logic et, ef;
    int len;
    issue(op, tag, w, off);
    a = w[53:0]; len = int'(w[59:54]); m = mk(len); s = a + off[53:0];
    ew = w; et = tag; ef = 1'b0;
    if (op == 2'd0) begin
      ew = {w[63:54], s};
      et = tag && ((len >= 54) || ((a >> len) == (s >> len)));
    end else if (op == 2'd1) ef = !tag || !w[60];
    else if (op == 2'd2) ef = !tag || !w[61];
    chk(rsp_valid === 1'b1, "R2 rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_word === ew, "R4/R8/R9 rsp_word", rsp_word, ew);
    chk(rsp_tag === et, "R5/R6 rsp_tag", 64'(rsp_tag), 64'(et));
    chk(rsp_fault === ef, "R7/R8 rsp_fault", 64'(rsp_fault), 64'(ef));
    chk(rsp_base === (a & ~m), "R3 rsp_base", 64'(rsp_base), 64'(a & ~m));
    chk(rsp_limit === (a | m), "R3 rsp_limit", 64'(rsp_limit), 64'(a | m));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  localparam logic [53:0] ADDRS [4] = '{54'h1234, 54'h0, 54'h3f_ffff_ffff_ffff, 54'h2a_5a5a_5a5a_5a5};
  localparam logic [63:0] OFFS [6] = '{64'd0, 64'd1, -64'sd1, 64'h100, -64'sd768, 64'h0040_0000_0000_0000};

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rsp_valid === 1'b0 && rsp_tag === 1'b0 && rsp_fault === 1'b0, "R10 reset flags",
        {61'd0, rsp_valid, rsp_tag, rsp_fault}, 64'd0);
    chk(rsp_word === '0 && rsp_base === '0 && rsp_limit === '0, "R10 reset data", rsp_word, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 idle
    chk(rsp_valid === 1'b0, "R2 idle", 64'(rsp_valid), 64'd0);

    // R3 worked example, R1 layout
    issue(2'd3, 1'b1, {4'h3, 6'd8, 54'h1234}, 64'd0);
    chk(rsp_base === 54'h1200, "R3 example base", 64'(rsp_base), 64'h1200);
    chk(rsp_limit === 54'h12ff, "R3 example limit", 64'(rsp_limit), 64'h12ff);

    // R4 R5 R7 add sweep over all lengths
    for (int len = 0; len < 64; len++)
      for (int ai = 0; ai < 4; ai++)
        for (int oi = 0; oi < 6; oi++)
          for (int t = 0; t < 2; t++)
            check_req(2'd0, 1'(t), {4'h5, 6'(len), ADDRS[ai]}, OFFS[oi]);

    // R8 R9 check sweep, all permissions and tags (R1 op codes 1,2,3)
    for (int op = 1; op < 4; op++)
      for (int p = 0; p < 16; p++)
        for (int t = 0; t < 2; t++)
          check_req(2'(op), 1'(t), {4'(p), 6'd12, 54'h0abc_def0}, 64'd0);

    // R6 leave the segment and come back: tag stays clear
    issue(2'd0, 1'b1, {4'h3, 6'd8, 54'h12f0}, 64'h20);
    chk(rsp_tag === 1'b0, "R6 left segment", 64'(rsp_tag), 64'd0);
    begin
      logic [63:0] w;
      logic t;
      w = rsp_word; t = rsp_tag;
      issue(2'd0, t, w, -64'sd32);
      chk(rsp_word[53:0] === 54'h12f0, "R6 back address", 64'(rsp_word[53:0]), 64'h12f0);
      chk(rsp_tag === 1'b0, "R6 back tag", 64'(rsp_tag), 64'd0);
      issue(2'd1, rsp_tag, rsp_word, 64'd0);
      chk(rsp_fault === 1'b1, "R6 untagged load faults", 64'(rsp_fault), 64'd1);
    end

    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 idle after burst", 64'(rsp_valid), 64'd0);
    done = 1;
    finish_run();
  end
endmodule